// File: doc/BRIEF.md
# Fuse-Configurable Programmable Logic Array

This block is a synthesizable soft model of a small combinational programmable logic array. Eight dedicated inputs and ten bidirectional pins feed an AND plane; every pin is split into a separate pad input, pad output and output-enable port. Both planes are programmable. Any of the 32 logic product terms can reach any or all of the ten OR gates. Each OR result passes through a per-output polarity XOR. Each pin also has its own direction product term, which drives that pin's output enable.

The fuse image is held in registers inside the block. It is loaded one word per clock through an address, data and write-enable port. A synchronous active-low reset restores the unprogrammed image. In that image every link is intact, so every term is inhibited, every output is quiet and every pin is an input. Apart from the fuse registers, the logic path is purely combinational. Pad inputs feed back into the AND plane in the same cycle. Loops that pass through external wiring are left to the surrounding system.

Top module: `pla_fabric`

## Requirements
- R1: The AND plane has 36 columns. Column 2k is the true form and column 2k+1 the complement form of signal k, where signals 0 to 7 are `in_ded[7:0]` and signals 8 to 17 are `pad_in[0]` to `pad_in[9]`. A term is the AND of every literal whose link bit is 1. A signal with both link bits 0 is a don't-care, and a term with no links evaluates to 1.
- R2: A term whose true and complement links for the same signal are both 1 evaluates to 0, whatever its inputs.
- R3: The raw result of output j is the OR of the logic terms 0 to 31 whose bit is set in output j's OR word. One term may feed any number of outputs.
- R4: `pad_out[j]` equals the raw result of output j XOR polarity bit j, where 1 means inverting (active-low) and 0 means non-inverting.
- R5: `pad_oe[j]` equals direction term j (AND word 32+j). When the pin is not driven, it acts purely as an AND-plane input through `pad_in[j]`.
- R6: An output whose OR word is all zero has a raw result of 0, so its `pad_out` equals its polarity bit.
- R7: The write map is as follows. Addresses 0 to 31 hold the logic-term AND words and addresses 32 to 41 the direction-term AND words (data bits 35:0). Addresses 42 to 51 hold the OR words of outputs 0 to 9 (data bits 31:0), with bit t selecting term t. Address 52 holds the polarity word (data bits 9:0). A write with `cfg_we` high takes effect at the clock edge, and the outputs reflect it from the next cycle.
- R8: Writes to addresses 53 to 63 change no fuse state and no output.
- R9: A clock edge with `rst_n` low sets every AND link and every OR link to 1 and every polarity bit to 0. Afterwards `pad_out` and `pad_oe` are all zero for any input.
- R10: Between writes, `pad_out` and `pad_oe` are combinational functions of `in_ded` and `pad_in`, so they follow an input change within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse registers |
| rst_n | input | 1 | Synchronous active-low reset to the unprogrammed image |
| cfg_we | input | 1 | Fuse word write enable |
| cfg_addr | input | 6 | Fuse word address |
| cfg_wdata | input | 36 | Fuse word data, low bits used for narrower words |
| in_ded | input | 8 | Dedicated logic inputs |
| pad_in | input | 10 | Values seen on the bidirectional pins, fed back into the AND plane |
| pad_out | output | 10 | Polarity-adjusted OR results toward the pins |
| pad_oe | output | 10 | Per-pin output enables from the direction terms |

## Verification
A corrupted link bit shows at the ports only when the input pattern makes the affected literal decisive. For that reason the decoder and multiplexer programs are swept across all of their select codes, and the probes move the other inputs as well. A bad AND, OR or polarity word is visible on `pad_out` or `pad_oe` in the cycle after the faulty write, since there is no pipeline. A write that lands at a wrong address disturbs an unrelated pin the next time that pin's terms become true. Reset and out-of-range writes are checked by probing every pin right after them.

// File: rtl/pla_pkg.sv
// Package: shared sizing defaults and helper functions for the logic array.
// Assumes: callers derive every width from the three base counts below.
package pla_pkg;

    localparam int unsigned PLA_N_IN   = 8;   // dedicated inputs
    localparam int unsigned PLA_N_PIN  = 10;  // bidirectional pins
    localparam int unsigned PLA_N_TERM = 32;  // shared logic product terms

    // Largest of three widths, used to size the write data bus.
    function automatic int unsigned pla_max3(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Address bits needed to reach every fuse word.
    function automatic int unsigned pla_addr_w(input int unsigned n_words);
        return (n_words <= 2) ? 1 : $clog2(n_words);
    endfunction

endpackage

// File: rtl/pla_fuse_store.sv
// Module: fuse image registers with a word-addressed write port.
// Assumes: one write per clock; addresses past the polarity word are ignored;
// reset image has every link intact and every output non-inverting.
module pla_fuse_store
    import pla_pkg::*;
#(
    parameter int unsigned N_IN   = PLA_N_IN,
    parameter int unsigned N_PIN  = PLA_N_PIN,
    parameter int unsigned N_TERM = PLA_N_TERM
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [pla_addr_w(N_TERM+2*N_PIN+1)-1:0] cfg_addr,
    input  logic [pla_max3(2*(N_IN+N_PIN), N_TERM, N_PIN)-1:0] cfg_wdata,
    output logic [(N_TERM+N_PIN)*2*(N_IN+N_PIN)-1:0] and_flat,
    output logic [N_PIN*N_TERM-1:0]           or_flat,
    output logic [N_PIN-1:0]                  pol_q
);
    localparam int unsigned N_SIG    = N_IN + N_PIN;
    localparam int unsigned N_COL    = 2 * N_SIG;
    localparam int unsigned N_AND    = N_TERM + N_PIN;
    localparam int unsigned OR_BASE  = N_AND;
    localparam int unsigned POL_ADDR = N_AND + N_PIN;
    localparam int unsigned ADDR_W   = pla_addr_w(POL_ADDR + 1);

    // One register word per AND term (logic terms then direction terms).
    for (genvar w = 0; w < N_AND; w++) begin : g_and_word
        logic [N_COL-1:0] word_q;
        // Purpose: hold the links of AND term w.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '1;
            else if (cfg_we && (cfg_addr == ADDR_W'(w)))
                word_q <= cfg_wdata[N_COL-1:0];
        end
        assign and_flat[w*N_COL +: N_COL] = word_q;
    end

    // One register word per output OR gate.
    for (genvar p = 0; p < N_PIN; p++) begin : g_or_word
        logic [N_TERM-1:0] word_q;
        // Purpose: hold which logic terms reach output p.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '1;
            else if (cfg_we && (cfg_addr == ADDR_W'(OR_BASE + p)))
                word_q <= cfg_wdata[N_TERM-1:0];
        end
        assign or_flat[p*N_TERM +: N_TERM] = word_q;
    end

    // Purpose: hold the per-output inversion bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_q <= '0;
        else if (cfg_we && (cfg_addr == ADDR_W'(POL_ADDR)))
            pol_q <= cfg_wdata[N_PIN-1:0];
    end

endmodule

// File: rtl/pla_and_plane.sv
// Module: programmable AND plane producing every product term.
// Assumes: signal k is offered as true (column 2k) and complement (column
// 2k+1); a set link bit includes that literal; no links gives a term of 1.
module pla_and_plane #(
    parameter int unsigned N_SIG = 18,
    parameter int unsigned N_AND = 42
) (
    input  logic [N_SIG-1:0]         sig_vec,
    input  logic [N_AND*2*N_SIG-1:0] and_flat,
    output logic [N_AND-1:0]         term_vec
);
    localparam int unsigned N_COL = 2 * N_SIG;

    logic [N_COL-1:0] lit_vec;

    // Literal columns: true and complement of each signal side by side.
    for (genvar k = 0; k < N_SIG; k++) begin : g_lit
        assign lit_vec[2*k]     = sig_vec[k];
        assign lit_vec[2*k + 1] = ~sig_vec[k];
    end

    // Each term passes only when every linked literal is high; a pair of
    // links on one signal can never both pass, which inhibits the term.
    for (genvar t = 0; t < N_AND; t++) begin : g_term
        logic [N_COL-1:0] links;
        assign links       = and_flat[t*N_COL +: N_COL];
        assign term_vec[t] = &(lit_vec | ~links);
    end

endmodule

// File: rtl/pla_or_plane.sv
// Module: programmable OR plane with per-output polarity XOR.
// Assumes: an output with no connected active terms yields 0 before the XOR.
module pla_or_plane #(
    parameter int unsigned N_TERM = 32,
    parameter int unsigned N_PIN  = 10
) (
    input  logic [N_TERM-1:0]       logic_terms,
    input  logic [N_PIN*N_TERM-1:0] or_flat,
    input  logic [N_PIN-1:0]        pol_q,
    output logic [N_PIN-1:0]        out_vec
);
    // Per output: gather connected terms, then apply polarity.
    for (genvar p = 0; p < N_PIN; p++) begin : g_out
        logic raw;
        assign raw        = |(logic_terms & or_flat[p*N_TERM +: N_TERM]);
        assign out_vec[p] = raw ^ pol_q[p];
    end

endmodule

// File: rtl/pla_fabric.sv
// Module: top of the fuse-configurable logic array.
// Assumes: pad feedback arrives on pad_in; the pad driver combines pad_out
// with pad_oe outside this block; loops through external pins are not handled.
module pla_fabric
    import pla_pkg::*;
#(
    parameter int unsigned N_IN   = PLA_N_IN,
    parameter int unsigned N_PIN  = PLA_N_PIN,
    parameter int unsigned N_TERM = PLA_N_TERM
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [pla_addr_w(N_TERM+2*N_PIN+1)-1:0] cfg_addr,
    input  logic [pla_max3(2*(N_IN+N_PIN), N_TERM, N_PIN)-1:0] cfg_wdata,
    input  logic [N_IN-1:0]              in_ded,
    input  logic [N_PIN-1:0]             pad_in,
    output logic [N_PIN-1:0]             pad_out,
    output logic [N_PIN-1:0]             pad_oe
);
    localparam int unsigned N_SIG = N_IN + N_PIN;
    localparam int unsigned N_COL = 2 * N_SIG;
    localparam int unsigned N_AND = N_TERM + N_PIN;

    logic [N_AND*N_COL-1:0]  and_flat;
    logic [N_PIN*N_TERM-1:0] or_flat;
    logic [N_PIN-1:0]        pol_q;
    logic [N_SIG-1:0]        sig_vec;
    logic [N_AND-1:0]        term_vec;

    // AND-plane inputs: dedicated inputs low, pin feedback above them.
    assign sig_vec = {pad_in, in_ded};

    pla_fuse_store #(
        .N_IN   (N_IN),
        .N_PIN  (N_PIN),
        .N_TERM (N_TERM)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .and_flat  (and_flat),
        .or_flat   (or_flat),
        .pol_q     (pol_q)
    );

    pla_and_plane #(
        .N_SIG (N_SIG),
        .N_AND (N_AND)
    ) u_and (
        .sig_vec  (sig_vec),
        .and_flat (and_flat),
        .term_vec (term_vec)
    );

    pla_or_plane #(
        .N_TERM (N_TERM),
        .N_PIN  (N_PIN)
    ) u_or (
        .logic_terms (term_vec[N_TERM-1:0]),
        .or_flat     (or_flat),
        .pol_q       (pol_q),
        .out_vec     (pad_out)
    );

    // Direction terms sit above the logic terms and drive the enables.
    assign pad_oe = term_vec[N_TERM +: N_PIN];

endmodule

// File: rtl/pla_fabric_chk.sv
// Module: property checker bound to pla_fabric.
// Assumes: rst_n is low at the first clock edge.
module pla_fabric_chk #(
    parameter int unsigned N_IN    = 8,
    parameter int unsigned N_PIN   = 10,
    parameter int unsigned N_TERM  = 32,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned AND_W   = 1512
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [ADDR_W-1:0]        cfg_addr,
    input logic [N_PIN-1:0]         pol_wdata,
    input logic [N_IN-1:0]          in_ded,
    input logic [N_PIN-1:0]         pad_in,
    input logic [N_PIN-1:0]         pad_out,
    input logic [N_PIN-1:0]         pad_oe,
    input logic [AND_W-1:0]         and_flat,
    input logic [N_PIN*N_TERM-1:0]  or_flat,
    input logic [N_PIN-1:0]         pol_q
);
    localparam int unsigned POL_ADDR = N_TERM + 2 * N_PIN;

    // First cycle after reset: every term inhibited, so nothing drives.
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0));

    // Polarity word write lands in the polarity register.
    a_r7_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && $past(cfg_addr) == ADDR_W'(POL_ADDR))
        |-> (pol_q == $past(pol_wdata)));

    // Writes beyond the map leave the whole fuse image untouched.
    a_r8_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && $past(cfg_addr) > ADDR_W'(POL_ADDR))
        |-> ($stable(and_flat) && $stable(or_flat) && $stable(pol_q)));

    // No write and steady inputs: outputs stay steady.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we) && $stable(in_ded) && $stable(pad_in))
        |-> ($stable(pad_out) && $stable(pad_oe)));

    // An empty OR word leaves only the polarity bit on the output.
    for (genvar p = 0; p < N_PIN; p++) begin : g_empty
        a_r6_empty_or: assert property (@(posedge clk) disable iff (!rst_n)
            (or_flat[p*N_TERM +: N_TERM] == '0) |-> (pad_out[p] == pol_q[p]));
    end

endmodule

bind pla_fabric pla_fabric_chk #(
    .N_IN   (N_IN),
    .N_PIN  (N_PIN),
    .N_TERM (N_TERM),
    .ADDR_W (pla_pkg::pla_addr_w(N_TERM+2*N_PIN+1)),
    .AND_W  ((N_TERM+N_PIN)*2*(N_IN+N_PIN))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .pol_wdata (cfg_wdata[N_PIN-1:0]),
    .in_ded    (in_ded),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .and_flat  (and_flat),
    .or_flat   (or_flat),
    .pol_q     (pol_q)
);

// File: tb/pla_fabric_bench.sv
// Bench: scoreboard. A driver task writes fuses, applies inputs and pushes the
// expected outputs; a monitor pops and compares a quarter cycle after each edge.
module pla_fabric_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8, NP = 10, NT = 32, NA = 42, NC = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [35:0] cfg_wdata = '0;
    logic [7:0]  in_ded = '0;
    logic [9:0]  pad_in = '0;
    logic [9:0]  pad_out, pad_oe;

    typedef struct {
        logic [9:0] out;
        logic [9:0] oe;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // Bench copy of the fuse image, kept from the requirements.
    logic [NC-1:0] m_and [NA];
    logic [NT-1:0] m_or  [NP];
    logic [NP-1:0] m_pol;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_fabric u_pla_fabric (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_ded(in_ded), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic void model_reset();
        for (int a = 0; a < NA; a++) m_and[a] = '1;
        for (int p = 0; p < NP; p++) m_or[p] = '1;
        m_pol = '0;
    endfunction

    function automatic logic [35:0] lit(input int sig, input bit tru);
        return 36'(1) << (tru ? 2*sig : 2*sig + 1);
    endfunction

    // R1/R2 literal rules, R3 OR, R4 XOR, R5 enables.
    function automatic void model_eval(input logic [7:0] di, input logic [9:0] pi,
                                       output logic [9:0] eo, output logic [9:0] eoe);
        logic [17:0] s;
        logic [41:0] t;
        s = {pi, di};
        for (int a = 0; a < NA; a++) begin
            t[a] = 1'b1;
            for (int k = 0; k < 18; k++) begin
                if (m_and[a][2*k] && !s[k])     t[a] = 1'b0;
                if (m_and[a][2*k+1] && s[k])    t[a] = 1'b0;
            end
        end
        for (int p = 0; p < NP; p++) begin
            eo[p]  = (|(t[31:0] & m_or[p])) ^ m_pol[p];
            eoe[p] = t[32+p];
        end
    endfunction

    task automatic cfg_write(input int addr, input logic [35:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
        if (addr < 42)       m_and[addr] = data;
        else if (addr < 52)  m_or[addr-42] = data[31:0];
        else if (addr == 52) m_pol = data[9:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic probe(input logic [7:0] di, input logic [9:0] pi, input string tag);
        exp_t e;
        @(negedge clk);
        in_ded = di; pad_in = pi;
        model_eval(di, pi, e.out, e.oe);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare every queued item a quarter cycle after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (pad_out !== e.out || pad_oe !== e.oe) begin
                    fails++;
                    $display("FAIL %s out=%h oe=%h expected out=%h oe=%h",
                             e.tag, pad_out, pad_oe, e.out, e.oe);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] w;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: unprogrammed image is quiet.
        probe(8'h00, 10'h000, "R9 reset image");
        probe(8'hFF, 10'h3FF, "R9 reset image");
        probe(8'hA5, 10'h2B6, "R9 reset image");

        // 3-to-8 decoder on in_ded[2:0] to pins 0..7 (R1, R3, R5, R7).
        for (int t = 0; t < 8; t++) begin
            w = '0;
            for (int b = 0; b < 3; b++) w |= lit(b, t[b]);
            cfg_write(t, w);
            cfg_write(32 + t, 36'h0);          // empty direction term: driven
            cfg_write(42 + t, 36'(1) << t);
        end
        cfg_write(42 + 7, 36'h81);             // pin 7 shares term 0 (R3)
        for (int v = 0; v < 8; v++)
            probe(8'({5'(v*5), 3'(v)}), 10'(v*37), "R1 R3 R5 decoder");

        // R4: invert pin 0 and pin 3.
        cfg_write(52, 36'h009);
        probe(8'h00, 10'h000, "R4 polarity");
        probe(8'h03, 10'h000, "R4 polarity");
        probe(8'h06, 10'h155, "R4 polarity");

        // R6: empty OR word on pin 4 with inversion yields 1.
        cfg_write(42 + 4, 36'h0);
        cfg_write(52, 36'h019);
        probe(8'h04, 10'h000, "R6 empty OR");
        probe(8'h01, 10'h3FF, "R6 empty OR");

        // R5: pin 6 enabled only when in_ded[7] is high.
        cfg_write(32 + 6, lit(7, 1'b1));
        probe(8'h06, 10'h000, "R5 enable low");
        probe(8'h86, 10'h000, "R5 enable high");

        // Mux on pin 9: ~i3 & pad_in[8] | i3 & i4 (R1, R3, R10 feedback).
        cfg_write(8, lit(3, 1'b0) | lit(16, 1'b1));
        cfg_write(9, lit(3, 1'b1) | lit(4, 1'b1));
        cfg_write(42 + 9, 36'h300);
        cfg_write(32 + 9, 36'h0);
        for (int v = 0; v < 8; v++)
            probe(8'({3'(v), 3'b000, 2'(v)}) | 8'({v[1], 3'b000}),
                  10'({v[2], 8'h00}), "R3 R10 mux");
        probe(8'h08, 10'h000, "R10 mux sel");
        probe(8'h18, 10'h000, "R10 mux sel");

        // R2: term 10 holds both links of in_ded[5]; wired to pin 5.
        cfg_write(10, lit(5, 1'b1) | lit(5, 1'b0));
        cfg_write(42 + 5, 36'(1) << 5 | 36'(1) << 10);
        probe(8'h20, 10'h000, "R2 inhibit");
        probe(8'h00, 10'h000, "R2 inhibit");
        probe(8'h25, 10'h000, "R2 inhibit");

        // R8: writes past the map change nothing.
        cfg_write(53, 36'h0);
        cfg_write(63, 36'h0);
        probe(8'h02, 10'h100, "R8 out of range");
        probe(8'h87, 10'h000, "R8 out of range");

        // R7: boundary direction word 41 and OR word 51.
        cfg_write(41, lit(0, 1'b1));
        probe(8'h00, 10'h100, "R7 last dir word");
        probe(8'h01, 10'h100, "R7 last dir word");

        // R9: reset after programming restores the quiet image.
        do_reset();
        probe(8'h00, 10'h000, "R9 reset again");
        probe(8'h5A, 10'h3C3, "R9 reset again");

        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule